// File: doc/BRIEF.md
# Floating-Point NaN Classifier and Propagator

This stage sits at the entrance of a floating-point operator. It accepts one or two IEEE binary operands (binary32 by default, binary64 by parameter) and reports a class for each: zero, infinity, quiet NaN, signaling NaN or other. When at least one considered operand is a NaN, it produces the NaN that the operator must return. That NaN is always quiet, and its payload and sign come from the selected input. The stage also raises an invalid-operation flag whenever a signaling NaN was presented.

The quiet-bit meaning is chosen per transaction. In the default mode a set top significand bit marks a quiet NaN. In the legacy mode a set top significand bit marks a signaling NaN. Quieting in legacy mode clears that bit. If clearing it would leave an all-zero significand, which would encode an infinity, the stage emits a canonical quiet NaN instead. Results are registered: one cycle after `in_valid`, `out_valid` rises together with the result fields.

Top module: `nan_prop_stage`

## Requirements
- R1: Each operand is classified by exponent and significand only, with the sign ignored. The class codes are 0 = other, 1 = zero, 2 = infinity (exponent all ones, significand zero), 3 = quiet NaN and 4 = signaling NaN (exponent all ones, significand nonzero).
- R2: With `two_op` low, operand B is ignored. `out_cls_b` reads 0, and B has no effect on `out_result`, `out_nan` or `out_invalid`.
- R3: With `legacy_mode` low, a signaling NaN is quieted by setting the top significand bit (bit MAN_W-1). The sign and all other bits are kept.
- R4: With `legacy_mode` high, a signaling NaN is quieted by clearing bit MAN_W-1. If the significand would then be zero, the result is instead the canonical NaN: sign 0, exponent all ones, significand 1.
- R5: A quiet NaN that is selected passes to `out_result` unchanged in either mode.
- R6: When both operands are NaNs, a signaling NaN is selected over a quiet one. If both are of the same kind, operand A is selected.
- R7: `out_invalid` is 1 exactly when a considered operand is a signaling NaN.
- R8: When no considered operand is a NaN, `out_nan` is 0, `out_result` is all zeros and `out_invalid` is 0.
- R9: `out_valid` is high in the cycle after `in_valid` was high, and low otherwise. Result fields hold their values while `in_valid` is low. An asserted `rst_n` (low) clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are presented this cycle |
| two_op | input | 1 | Operand B takes part |
| legacy_mode | input | 1 | 1: top significand bit set means signaling |
| op_a | input | EXP_W+MAN_W+1 | Operand A |
| op_b | input | EXP_W+MAN_W+1 | Operand B |
| out_valid | output | 1 | Registered result is valid |
| out_nan | output | 1 | A NaN result was produced |
| out_invalid | output | 1 | A signaling NaN was seen |
| out_result | output | EXP_W+MAN_W+1 | Quieted NaN, or zero |
| out_cls_a | output | 3 | Class of operand A |
| out_cls_b | output | 3 | Class of operand B, 0 when unused |

## Verification
Every result, including the class codes, the NaN, the invalid flag and `out_valid`, is due exactly one clock edge after the cycle in which its operands were driven. The bench drives inputs on the falling edge. On the next falling edge it compares all outputs with a behavioural model that was updated when those inputs were applied. This places each comparison one register stage after its stimulus. Idle cycles leave the model's data unchanged, so the hold behaviour is compared on the same schedule.

// File: rtl/nan_pkg.sv
package nan_pkg;
  typedef enum logic [2:0] {
    FC_OTHER = 3'd0,
    FC_ZERO  = 3'd1,
    FC_INF   = 3'd2,
    FC_QNAN  = 3'd3,
    FC_SNAN  = 3'd4
  } fclass_e;
endpackage

// File: rtl/nan_classify.sv
module nan_classify
  import nan_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] op,
  input  logic                 legacy,
  output fclass_e              cls
);
  logic [EXP_W-1:0] expf;
  logic [MAN_W-1:0] manf;
  logic             flag_quiet;

  assign expf = op[EXP_W+MAN_W-1:MAN_W];
  assign manf = op[MAN_W-1:0];
  assign flag_quiet = manf[MAN_W-1] ^ legacy;

  always_comb begin
    if (expf == '0 && manf == '0)      cls = FC_ZERO;
    else if (expf != '1)               cls = FC_OTHER;
    else if (manf == '0)               cls = FC_INF;
    else if (flag_quiet)               cls = FC_QNAN;
    else                               cls = FC_SNAN;
  end
endmodule

// File: rtl/nan_quieten.sv
module nan_quieten #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] nan_in,
  input  logic                 legacy,
  input  logic                 is_sig,
  output logic [EXP_W+MAN_W:0] nan_out
);
  localparam int W = EXP_W + MAN_W + 1;
  localparam logic [MAN_W-1:0] QBIT = {1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [W-1:0] CANON_LEG = {1'b0, {EXP_W{1'b1}}, {(MAN_W-1){1'b0}}, 1'b1};

  logic [MAN_W-1:0] man_clr;

  assign man_clr = nan_in[MAN_W-1:0] & ~QBIT;

  always_comb begin
    nan_out = nan_in;
    if (is_sig) begin
      if (!legacy)              nan_out[MAN_W-1] = 1'b1;
      else if (man_clr == '0)   nan_out = CANON_LEG;
      else                      nan_out[MAN_W-1] = 1'b0;
    end
  end
endmodule

// File: rtl/nan_pick.sv
module nan_pick (
  input  logic nan_a,
  input  logic sig_a,
  input  logic nan_b,
  input  logic sig_b,
  output logic take_b
);
  always_comb begin
    if (sig_a)       take_b = 1'b0;
    else if (sig_b)  take_b = 1'b1;
    else if (nan_a)  take_b = 1'b0;
    else             take_b = nan_b;
  end
endmodule

// File: rtl/nan_prop_stage.sv
module nan_prop_stage
  import nan_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 two_op,
  input  logic                 legacy_mode,
  input  logic [EXP_W+MAN_W:0] op_a,
  input  logic [EXP_W+MAN_W:0] op_b,
  output logic                 out_valid,
  output logic                 out_nan,
  output logic                 out_invalid,
  output logic [EXP_W+MAN_W:0] out_result,
  output logic [2:0]           out_cls_a,
  output logic [2:0]           out_cls_b
);
  localparam int W = EXP_W + MAN_W + 1;
  localparam int NOPS = 2;

  logic [W-1:0] ops [NOPS];
  fclass_e      cls_raw [NOPS];
  logic         is_nan [NOPS];
  logic         is_sig [NOPS];
  logic         use_op [NOPS];

  assign ops[0] = op_a;
  assign ops[1] = op_b;
  assign use_op[0] = 1'b1;
  assign use_op[1] = two_op;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    nan_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op     (ops[g]),
      .legacy (legacy_mode),
      .cls    (cls_raw[g])
    );
    assign is_sig[g] = use_op[g] && (cls_raw[g] == FC_SNAN);
    assign is_nan[g] = use_op[g] && (cls_raw[g] == FC_SNAN || cls_raw[g] == FC_QNAN);
  end

  logic         take_b;
  logic [W-1:0] chosen;
  logic [W-1:0] quiet_val;

  nan_pick u_pick (
    .nan_a  (is_nan[0]),
    .sig_a  (is_sig[0]),
    .nan_b  (is_nan[1]),
    .sig_b  (is_sig[1]),
    .take_b (take_b)
  );

  assign chosen = take_b ? op_b : op_a;

  nan_quieten #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_q (
    .nan_in  (chosen),
    .legacy  (legacy_mode),
    .is_sig  (take_b ? is_sig[1] : is_sig[0]),
    .nan_out (quiet_val)
  );

  logic         nxt_nan, nxt_inv;
  logic [W-1:0] nxt_res;
  logic [2:0]   nxt_cls_a, nxt_cls_b;

  always_comb begin
    nxt_nan   = is_nan[0] | is_nan[1];
    nxt_inv   = is_sig[0] | is_sig[1];
    nxt_res   = nxt_nan ? quiet_val : '0;
    nxt_cls_a = cls_raw[0];
    nxt_cls_b = two_op ? cls_raw[1] : FC_OTHER;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_nan     <= nxt_nan;
      out_invalid <= nxt_inv;
      out_result  <= nxt_res;
      out_cls_a   <= nxt_cls_a;
      out_cls_b   <= nxt_cls_b;
    end
  end
endmodule

// File: rtl/nan_prop_chk.sv
module nan_prop_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 two_op,
  input logic                 legacy_mode,
  input logic                 out_valid,
  input logic                 out_nan,
  input logic                 out_invalid,
  input logic [EXP_W+MAN_W:0] out_result,
  input logic [2:0]           out_cls_b
);
  a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_valid) |=> $stable(out_result));
  a_r7_inv_needs_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> out_nan);
  a_r8_nan_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_nan) |-> (out_result[EXP_W+MAN_W-1:MAN_W] == '1 &&
                                out_result[MAN_W-1:0] != '0));
  a_r8_zero_when_none: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_nan) |-> (out_result == '0 && !out_invalid));
  a_r3_quiet_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legacy_mode) |=> (!out_nan || out_result[MAN_W-1]));
  a_r4_quiet_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legacy_mode) |=> (!out_nan || !out_result[MAN_W-1]));
  a_r2_b_unused: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !two_op) |=> (out_cls_b == 3'd0));
endmodule

bind nan_prop_stage nan_prop_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .two_op(two_op),
  .legacy_mode(legacy_mode), .out_valid(out_valid), .out_nan(out_nan),
  .out_invalid(out_invalid), .out_result(out_result), .out_cls_b(out_cls_b)
);

// File: tb/sim_nan_prop_stage.sv
module sim_nan_prop_stage;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, two_op, legacy_mode;
  logic [31:0] op_a, op_b;
  logic        out_valid, out_nan, out_invalid;
  logic [31:0] out_result;
  logic [2:0]  out_cls_a, out_cls_b;

  always #10 clk = ~clk;

  nan_prop_stage u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .two_op(two_op),
    .legacy_mode(legacy_mode), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .out_nan(out_nan), .out_invalid(out_invalid),
    .out_result(out_result), .out_cls_a(out_cls_a), .out_cls_b(out_cls_b)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state
  bit          e_valid = 0, have_data = 0;
  bit          e_nan, e_inv;
  logic [31:0] e_res;
  int          e_ca, e_cb;
  string       t_res, t_cb;

  function automatic int classify(logic [31:0] x, bit leg);
    int e = int'(x[30:23]);
    int m = int'(x[22:0]);
    if (e == 0 && m == 0) return 1;
    if (e != 255) return 0;
    if (m == 0) return 2;
    if ((x[22] == 1'b1) != leg) return 3;
    return 4;
  endfunction

  function automatic logic [31:0] quieten(logic [31:0] x, bit leg);
    if (!leg) return x | 32'h0040_0000;
    if ((x & 32'h003F_FFFF) == 0) return 32'h7F80_0001;
    return x & ~32'h0040_0000;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R9 out_valid", {31'b0, out_valid}, {31'b0, e_valid});
    if (have_data && out_valid) begin
      chk(t_res, out_result, e_res);
      chk("R8 out_nan", {31'b0, out_nan}, {31'b0, e_nan});
      chk("R7 out_invalid", {31'b0, out_invalid}, {31'b0, e_inv});
      chk("R1 out_cls_a", {29'b0, out_cls_a}, e_ca[31:0]);
      chk(t_cb, {29'b0, out_cls_b}, e_cb[31:0]);
    end
  endtask

  task automatic model(logic [31:0] a, logic [31:0] b, bit two, bit leg, bit v);
    int ca, cb;
    bit na, nb, sa, sb, selb;
    e_valid = v;
    if (!v) return;
    ca = classify(a, leg);
    cb = classify(b, leg);
    na = (ca >= 3);
    sa = (ca == 4);
    nb = two && (cb >= 3);
    sb = two && (cb == 4);
    if (sa) selb = 0;
    else if (sb) selb = 1;
    else if (na) selb = 0;
    else selb = nb;
    e_nan = na || nb;
    e_inv = sa || sb;
    e_ca = ca;
    e_cb = two ? cb : 0;
    t_cb = two ? "R1 out_cls_b" : "R2 out_cls_b";
    if (!e_nan) begin
      e_res = 0;
      t_res = (!two && cb >= 3) ? "R2 result" : "R8 result";
    end else begin
      logic [31:0] pick;
      bit psig;
      pick = selb ? b : a;
      psig = selb ? sb : sa;
      e_res = psig ? quieten(pick, leg) : pick;
      if (na && nb) t_res = "R6 result";
      else if (!two && cb >= 3) t_res = "R2 result";
      else if (psig) t_res = leg ? "R4 result" : "R3 result";
      else t_res = "R5 result";
    end
    have_data = 1;
  endtask

  task automatic step(logic [31:0] a, logic [31:0] b, bit two, bit leg, bit v);
    @(negedge clk);
    compare();
    op_a = a; op_b = b; two_op = two; legacy_mode = leg; in_valid = v;
    model(a, b, two, leg, v);
  endtask

  function automatic logic [31:0] mkop(int kind);
    logic [31:0] r = $urandom;
    case (kind)
      0: r[30:23] = 8'hFF;                         // any NaN/inf
      1: begin r[30:23] = 8'hFF; r[22:0] = 23'h400000; end
      2: begin r[30:23] = 8'hFF; r[22:0] = 23'h1; end
      3: r[30:0] = 0;
      default: ;
    endcase
    return r;
  endfunction

  initial begin
    rst_n = 0; in_valid = 0; two_op = 0; legacy_mode = 0; op_a = 0; op_b = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset out_valid", {31'b0, out_valid}, 32'd0);
    rst_n = 1;
    // R1 classes, sign ignored
    step(32'h0000_0000, 32'h8000_0000, 1, 0, 1);
    step(32'hFF80_0000, 32'h3F80_0000, 1, 0, 1);
    // R3 is-quiet mode quieting of signaling NaN
    step(32'hFF80_1234, 32'h0, 0, 0, 1);
    // R4 legacy: clear flag, and canonical substitute
    step(32'h7FC0_0005, 32'h0, 0, 1, 1);
    step(32'hFFC0_0000, 32'h0, 0, 1, 1);
    // R5 quiet NaN passes
    step(32'h7FC0_ABCD, 32'h0, 0, 0, 1);
    step(32'h7F80_0077, 32'h0, 0, 1, 1);
    // R6 priority
    step(32'h7FC0_0001, 32'h7F80_0002, 1, 0, 1);
    step(32'h7FC0_0003, 32'hFFC0_0004, 1, 0, 1);
    step(32'h7F80_0005, 32'hFF80_0006, 1, 0, 1);
    // R2 operand B ignored
    step(32'h3F80_0000, 32'h7F80_0009, 0, 0, 1);
    // R9 idle hold
    step(32'h7F80_1111, 32'h7F80_2222, 1, 0, 0);
    step(32'h7F80_1111, 32'h7F80_2222, 1, 0, 0);
    // R9 reset mid stream
    step(32'h7FC0_0000, 32'h0, 1, 0, 1);
    @(negedge clk);
    rst_n = 0;
    #1;
    chk("R9 async clear", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1; in_valid = 0;
    e_valid = 0;
    // random mix
    for (int i = 0; i < 400; i++)
      step(mkop($urandom_range(0, 5)), mkop($urandom_range(0, 5)),
           1'($urandom), 1'($urandom), ($urandom_range(0, 3) != 0));
    step(32'h0, 32'h0, 0, 0, 0);
    step(32'h0, 32'h0, 0, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule